// File: doc/BRIEF.md
# Stream Group Sync Monitor

This monitor sits on the input stream of a punctured convolutional encoder. The encoder consumes input bits in groups of a fixed length, and the upstream source marks the final bit of each group with a last flag. The monitor checks that this framing agrees with the encoder's own grouping. It keeps a private position counter over accepted input transfers, modulo the group length. On every accepted transfer it compares the sampled last flag with the position where a group must close.

Two held event outputs report a disagreement. One output means the closing bit of a group arrived without the last flag. The other means the last flag arrived on a bit that does not close a group. A flag output keeps its value until the next accepted transfer, and is then recomputed. The monitor never realigns its counter on a mismatch, so the position always follows its own grouping. After a mismatch the system decides whether to reset. The last flag only feeds this check. If the event outputs are not used, it may be tied to either level.

Top module: `grp_sync_mon`

## Requirements
- R1: While rst_ni is low, and after it is released, both event outputs are low and the position counter is zero. The first accepted transfer after reset is therefore position 0.
- R2: When the transfer at position GROUP_LEN-1 is accepted with s_tlast_i low, missing_o is high from the next clock edge and unexpected_o is low.
- R3: When a transfer at a position below GROUP_LEN-1 is accepted with s_tlast_i high, unexpected_o is high from the next clock edge and missing_o is low.
- R4: In a cycle with no accepted transfer, both event outputs keep their previous values.
- R5: A transfer is accepted only when s_tvalid_i, s_tready_i and en_i are all high at a rising edge. No other cycle advances the position or changes the outputs, whatever the level of s_tlast_i.
- R6: A mismatch leaves the position counting unchanged: it advances by one on each accepted transfer, exactly as it does on a correctly framed one.
- R7: At most one event output is high at a time. An accepted transfer with correct framing drives both outputs low.
- R8: The position wraps from GROUP_LEN-1 to 0, so every GROUP_LEN-th accepted transfer closes a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; low freezes the monitor |
| s_tvalid_i | input | 1 | Input stream valid |
| s_tready_i | input | 1 | Input stream ready |
| s_tlast_i | input | 1 | Upstream group-end marker |
| missing_o | output | 1 | Group closed without a marker |
| unexpected_o | output | 1 | Marker seen inside a group |

## Verification
The position wrap and a flag decision fall in the same cycle whenever the closing transfer of a group is accepted. That one edge must reset the position to zero and also set or clear missing_o from the sampled marker. The bench provokes this both with directed groups and with random markers on closing transfers. It also misplaces markers just before the wrap, and stalls the transfer, or drops the clock enable, exactly on the closing position. A reference model of the position, built from the requirements, judges the outputs one edge later. That edge shows whether the wrap stayed aligned and whether the correct flag was raised.

// File: rtl/grp_sync_pkg.sv
package grp_sync_pkg;
  typedef struct packed {
    logic missing;
    logic unexpected;
  } sync_evt_t;
endpackage

// File: rtl/grp_phase_ctr.sv
module grp_phase_ctr #(
  parameter int GROUP_LEN    = 3,
  parameter bit PHASE_ONEHOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  output logic last_slot_o
);
  localparam int CNT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

  generate
    if (PHASE_ONEHOT) begin : g_ring
      logic [GROUP_LEN-1:0] ring_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ring_q <= {{(GROUP_LEN-1){1'b0}}, 1'b1};
        else if (acc_i) ring_q <= {ring_q[GROUP_LEN-2:0], ring_q[GROUP_LEN-1]};
      end
      assign last_slot_o = ring_q[GROUP_LEN-1];

      a_r8_ring_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(ring_q));
      a_r5_ring_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_i |=> $stable(ring_q));
    end else begin : g_bin
      localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_LEN-1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (acc_i) begin
          if (cnt_q == LAST)     cnt_q <= '0;
          else                   cnt_q <= cnt_q + 1'b1;
        end
      end
      assign last_slot_o = (cnt_q == LAST);

      a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_i && last_slot_o |=> cnt_q == '0);
      a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
      a_r5_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_i |=> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/grp_evt_eval.sv
module grp_evt_eval
  import grp_sync_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      acc_i,
  input  logic      last_slot_i,
  input  logic      tlast_i,
  output sync_evt_t evt_o
);
  sync_evt_t evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else if (acc_i) begin
      evt_q.missing    <= last_slot_i & ~tlast_i;
      evt_q.unexpected <= ~last_slot_i & tlast_i;
    end
  end
  assign evt_o = evt_q;

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(evt_q));
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_q.missing, evt_q.unexpected}));
endmodule

// File: rtl/grp_sync_mon.sv
module grp_sync_mon
  import grp_sync_pkg::*;
#(
  parameter int GROUP_LEN    = 3,
  parameter bit PHASE_ONEHOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic s_tvalid_i,
  input  logic s_tready_i,
  input  logic s_tlast_i,
  output logic missing_o,
  output logic unexpected_o
);
  logic      acc;
  logic      last_slot;
  sync_evt_t evt;

  assign acc = s_tvalid_i & s_tready_i & en_i;

  grp_phase_ctr #(
    .GROUP_LEN   (GROUP_LEN),
    .PHASE_ONEHOT(PHASE_ONEHOT)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .last_slot_o(last_slot)
  );

  grp_evt_eval u_eval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .last_slot_i(last_slot),
    .tlast_i    (s_tlast_i),
    .evt_o      (evt)
  );

  assign missing_o    = evt.missing;
  assign unexpected_o = evt.unexpected;

  initial begin
    a_r8_len: assert (GROUP_LEN >= 2);
  end

  a_r2_missing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && last_slot && !s_tlast_i |=> missing_o && !unexpected_o);
  a_r3_unexpected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !last_slot && s_tlast_i |=> unexpected_o && !missing_o);
  a_r7_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (last_slot == s_tlast_i) |=> !missing_o && !unexpected_o);
endmodule

// File: tb/grp_sync_mon_tb.sv
`timescale 1ns/1ps
module grp_sync_mon_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, vld = 1'b0, rdy = 1'b0, lst = 1'b0;
  logic miss, unexp;

  int vectors = 0;
  int errors  = 0;
  int ph = 0;
  bit em = 0, eu = 0;

  always #4 clk = ~clk;

  grp_sync_mon #(.GROUP_LEN(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .s_tvalid_i(vld), .s_tready_i(rdy), .s_tlast_i(lst),
    .missing_o(miss), .unexpected_o(unexp)
  );

  task automatic check(string tag);
    vectors++;
    if (miss !== em || unexp !== eu) begin
      errors++;
      $display("FAIL %s: missing=%0b unexpected=%0b expected missing=%0b unexpected=%0b",
               tag, miss, unexp, em, eu);
    end
  endtask

  // called at a negedge: drive, update the model, clock, check
  task automatic step(bit v, bit r, bit e, bit l, string tag);
    vld = v; rdy = r; en = e; lst = l;
    if (v && r && e) begin
      if (ph == N-1) begin em = !l; eu = 0; ph = 0; end
      else           begin em = 0;  eu = l; ph = ph + 1; end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; vld = 0; rdy = 0; en = 0; lst = 0;
    em = 0; eu = 0; ph = 0;
    @(negedge clk); @(negedge clk);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R8/R7: two correctly framed groups
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < N; k++) step(1, 1, 1, k == N-1, "R8 clean framing");

    // R2: closing bit without marker
    step(1, 1, 1, 0, "R7 slot0");
    step(1, 1, 1, 0, "R7 slot1");
    step(1, 1, 1, 0, "R2 missing");
    // R4: held across idle cycles with misleading marker
    step(0, 1, 1, 1, "R4 hold valid low");
    step(0, 0, 0, 0, "R4 hold idle");
    // R3: marker at slot0; R7 next clean bit clears it
    step(1, 1, 1, 1, "R3 unexpected");
    step(1, 1, 1, 0, "R7 clear");
    // R5: closing slot with each qualifier low, marker toggled
    step(1, 1, 0, 0, "R5 enable low");
    step(1, 0, 1, 0, "R5 ready low");
    step(0, 1, 1, 0, "R5 valid low");
    step(1, 1, 1, 1, "R5 close after stalls");
    // R6: misplaced marker just before wrap, phase kept
    step(1, 1, 1, 0, "R6 slot0");
    step(1, 1, 1, 1, "R6 marker slot1");
    step(1, 1, 1, 1, "R6 close still aligned");
    step(1, 1, 1, 0, "R6 next slot0 clean");

    // mid-stream reset returns phase to zero
    step(1, 1, 1, 0, "R1 pre-reset slot1");
    do_reset();
    step(1, 1, 1, 0, "R1 first slot");
    step(1, 1, 1, 0, "R1 second slot");
    step(1, 1, 1, 1, "R1 close");

    // random mix: R2 R3 R4 R5 R6
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit r = ($urandom % 4) != 0;
      bit e = ($urandom % 8) != 0;
      bit l = (($urandom % 6) == 0) ? ~(ph == N-1) : (ph == N-1);
      step(v, r, e, l, "R2/R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule